// File: doc/BRIEF.md
# Load-Store Queue with Store-to-Load Forwarding

This block holds the in-flight memory operations of an out-of-order core in program order, oldest at the head. Each slot records whether the operation reads or writes memory, its sequence number, and an address and a data word, each with its own valid flag. Address and data arrive after dispatch, from separate update ports that name the target slot by sequence number.

A read goes out only when no older write in the queue still has an unknown address. When a read goes out, the queue looks back from it toward the head for the nearest older write to the same word. If it finds one, that write's data is returned. If it finds none, the read goes to the data cache read port. A matching write whose data has not yet arrived holds the read back. Writes reach the cache only when they retire from the head.

A flush drops every entry younger than a given sequence number. Sequence order wraps around, so age is judged by the sign of the difference. Accesses are whole, aligned words, so an address match is exact equality. DEPTH must be a power of two.

Top module: `memq_lsq`

## Requirements
- R1: After reset the queue is empty, `disp_ready` is 1, and `cache_rd_en`, `cache_wr_en` and `ld_resp_valid` are 0.
- R2: Dispatch appends at the tail in order. `disp_ready` is 0 when DEPTH entries are held or while `flush_valid` is 1. Otherwise it is 1.
- R3: A read is not issued while any older write in the queue has no valid address.
- R4: An issued read returns the data of the youngest older write whose address equals its own, with `ld_resp_fwd`=1. Writes younger than the read are never used as a source.
- R5: If that nearest matching older write has no valid data yet, the read waits and makes no cache access until the data arrives.
- R6: With no matching older write, the read drives `cache_rd_en`=1 and `cache_rd_addr` in its issue cycle. The response in the next cycle carries `cache_rd_data` with `ld_resp_fwd`=0.
- R7: Every response comes exactly one cycle after issue and carries the read's sequence number. At most one read issues per cycle, the oldest ready read first, and each read issues once.
- R8: A commit without flush removes the head entry. If the head is a write, `cache_wr_en`=1 with its address and data in that same cycle. A read at the head, or a commit on an empty queue, makes no cache write.
- R9: `cache_wr_en` is never 1 except in a commit cycle, so a write leaves memory untouched before it commits.
- R10: A flush keeps the entries whose sequence number is not younger than `flush_seq`. Younger means that (seq - `flush_seq`) is positive as a signed SW-bit value, so the check works across wrap. In a flush cycle, dispatch, commit and read issue are all suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_is_store | input | 1 | 1 = write, 0 = read |
| disp_seq | input | SW | Sequence number of dispatched entry |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| addr_upd_valid | input | 1 | Address update strobe |
| addr_upd_seq | input | SW | Entry receiving the address |
| addr_upd_addr | input | AW | Word address |
| data_upd_valid | input | 1 | Write-data update strobe |
| data_upd_seq | input | SW | Write entry receiving data |
| data_upd_data | input | DW | Write data |
| commit_valid | input | 1 | Retire the head entry |
| flush_valid | input | 1 | Flush request |
| flush_seq | input | SW | Entries younger than this are removed |
| cache_rd_en | output | 1 | Cache read request |
| cache_rd_addr | output | AW | Cache read address |
| cache_rd_data | input | DW | Cache read data, one cycle after request |
| cache_wr_en | output | 1 | Cache write at commit |
| cache_wr_addr | output | AW | Cache write address |
| cache_wr_data | output | DW | Cache write data |
| ld_resp_valid | output | 1 | Read result valid |
| ld_resp_seq | output | SW | Sequence number of the read |
| ld_resp_data | output | DW | Read result |
| ld_resp_fwd | output | 1 | 1 = data forwarded from a write |

## Verification
The forwarding search is exercised with two older writes against one read, in several arrangements:
- Neither write matches. This separates a cache read from a forward.
- Only the older write matches. This shows the search reaches past a non-matching younger write.
- Both writes match, with the older data arriving first. Only a response holding the younger write's value tells "youngest match" apart from "first match found".
- The addresses differ by one. This rules out partial address comparison.

Directed cases cover the stall patterns, each of which a design that issues too early answers with a response too soon:
- An older write with an unknown address.
- A matching write that has no data yet.
- A younger write to the same address.

Flushes are also tried across the sequence-number wrap.

// File: rtl/memq_pkg.sv
package memq_pkg;

  // Per-slot status flags
  typedef struct packed {
    logic is_st;
    logic addr_v;
    logic data_v;
    logic issued;
  } memq_flags_t;

  // Source of a read result
  typedef enum logic {
    SRC_CACHE = 1'b0,
    SRC_FWD   = 1'b1
  } memq_src_t;

endpackage

// File: rtl/memq_rst_sync.sv
module memq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/memq_ptrs.sv
module memq_ptrs #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [PW:0]   keep_cnt,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [PW:0]   count
);
  logic [PW-1:0] head_d, tail_d;
  logic [PW:0]   count_d;
  logic          upd_en;

  always_comb begin
    head_d  = head;
    tail_d  = tail;
    count_d = count;
    if (flush) begin
      tail_d  = head + keep_cnt[PW-1:0];
      count_d = keep_cnt;
    end else begin
      if (pop)  head_d = head + 1'b1;
      if (push) tail_d = tail + 1'b1;
      case ({push, pop})
        2'b10:   count_d = count + 1'b1;
        2'b01:   count_d = count - 1'b1;
        default: count_d = count;
      endcase
    end
  end

  assign upd_en = flush | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (upd_en) begin
      head  <= head_d;
      tail  <= tail_d;
      count <= count_d;
    end
  end
endmodule

// File: rtl/memq_pick.sv
module memq_pick #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         v,
  input  logic [DEPTH-1:0]         is_st,
  input  logic [DEPTH-1:0]         addr_v,
  input  logic [DEPTH-1:0]         data_v,
  input  logic [DEPTH-1:0]         issued,
  input  logic [DEPTH-1:0][AW-1:0] addr,
  input  logic [DEPTH-1:0][DW-1:0] data,
  output logic                     found,
  output logic [PW-1:0]            pos,
  output logic                     fwd,
  output logic [DW-1:0]            fwd_data,
  output logic [AW-1:0]            ld_addr
);
  // Inputs are in age order: index 0 is the oldest entry.
  logic [DEPTH-1:0]         rdy;
  logic [DEPTH-1:0]         hit;
  logic [DEPTH-1:0][DW-1:0] hit_data;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      logic blocked, h, hdv;
      logic [DW-1:0] hd;
      blocked = 1'b0;
      h       = 1'b0;
      hdv     = 1'b0;
      hd      = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (i < j && v[i] && is_st[i]) begin
          if (!addr_v[i]) begin
            blocked = 1'b1;
          end else if (addr[i] == addr[j]) begin
            // later i is younger: overrides, leaving the nearest match
            h   = 1'b1;
            hdv = data_v[i];
            hd  = data[i];
          end
        end
      end
      rdy[j]      = v[j] & ~is_st[j] & addr_v[j] & ~issued[j] & ~blocked & (~h | hdv);
      hit[j]      = h;
      hit_data[j] = hd;
    end
  end

  always_comb begin
    found    = 1'b0;
    pos      = '0;
    fwd      = 1'b0;
    fwd_data = '0;
    ld_addr  = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (rdy[j]) begin
        found    = 1'b1;
        pos      = PW'(j);
        fwd      = hit[j];
        fwd_data = hit_data[j];
        ld_addr  = addr[j];
      end
    end
  end
endmodule

// File: rtl/memq_lsq.sv
module memq_lsq #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int SW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic          disp_is_store,
  input  logic [SW-1:0] disp_seq,
  output logic          disp_ready,
  input  logic          addr_upd_valid,
  input  logic [SW-1:0] addr_upd_seq,
  input  logic [AW-1:0] addr_upd_addr,
  input  logic          data_upd_valid,
  input  logic [SW-1:0] data_upd_seq,
  input  logic [DW-1:0] data_upd_data,
  input  logic          commit_valid,
  input  logic          flush_valid,
  input  logic [SW-1:0] flush_seq,
  output logic          cache_rd_en,
  output logic [AW-1:0] cache_rd_addr,
  input  logic [DW-1:0] cache_rd_data,
  output logic          cache_wr_en,
  output logic [AW-1:0] cache_wr_addr,
  output logic [DW-1:0] cache_wr_data,
  output logic          ld_resp_valid,
  output logic [SW-1:0] ld_resp_seq,
  output logic [DW-1:0] ld_resp_data,
  output logic          ld_resp_fwd
);
  import memq_pkg::*;

  localparam int PW = $clog2(DEPTH);

  logic          rst_sync_n;
  logic [PW-1:0] head_q, tail_q;
  logic [PW:0]   count_q, keep_cnt;
  logic          do_push, do_pop, do_issue, q_full, q_empty;

  // slot storage (no reset: validity comes from the pointers)
  logic [DEPTH-1:0][SW-1:0] seq_q, seq_d;
  logic [DEPTH-1:0][AW-1:0] addr_q, addr_d;
  logic [DEPTH-1:0][DW-1:0] data_q, data_d;
  memq_flags_t [DEPTH-1:0]  flg_q, flg_d;
  logic [DEPTH-1:0]         slot_en, slot_v;

  // age-ordered view
  logic [DEPTH-1:0]         age_v, age_st, age_av, age_dv, age_iss;
  logic [DEPTH-1:0][AW-1:0] age_addr;
  logic [DEPTH-1:0][DW-1:0] age_data;
  logic [DEPTH-1:0][SW-1:0] age_seq;

  logic          pick_found, pick_fwd;
  logic [PW-1:0] pick_pos, issue_slot;
  logic [DW-1:0] pick_fdata;
  logic [AW-1:0] pick_addr;

  logic          resp_v_q;
  logic [SW-1:0] resp_seq_q;
  memq_src_t     resp_src_q;
  logic [DW-1:0] resp_fdata_q;

  memq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  memq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (do_push),
    .pop      (do_pop),
    .flush    (flush_valid),
    .keep_cnt (keep_cnt),
    .head     (head_q),
    .tail     (tail_q),
    .count    (count_q)
  );

  assign q_full   = (count_q == (PW+1)'(DEPTH));
  assign q_empty  = (count_q == '0);
  assign disp_ready = ~q_full & ~flush_valid;
  assign do_push  = disp_valid & disp_ready;
  assign do_pop   = commit_valid & ~flush_valid & ~q_empty;

  // age view and slot occupancy
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PW-1:0] idx, off;
    assign idx         = head_q + PW'(k);
    assign off         = PW'(k) - head_q;
    assign slot_v[k]   = ({1'b0, off} < count_q);
    assign age_v[k]    = ((PW+1)'(k) < count_q);
    assign age_st[k]   = flg_q[idx].is_st;
    assign age_av[k]   = flg_q[idx].addr_v;
    assign age_dv[k]   = flg_q[idx].data_v;
    assign age_iss[k]  = flg_q[idx].issued;
    assign age_addr[k] = addr_q[idx];
    assign age_data[k] = data_q[idx];
    assign age_seq[k]  = seq_q[idx];
  end

  // entries kept by a flush: a prefix of the age order
  always_comb begin
    keep_cnt = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [SW-1:0] diff;
      diff = age_seq[k] - flush_seq;
      if (age_v[k] && !($signed(diff) > 0)) keep_cnt = keep_cnt + 1'b1;
    end
  end

  memq_pick #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_pick (
    .v        (age_v),
    .is_st    (age_st),
    .addr_v   (age_av),
    .data_v   (age_dv),
    .issued   (age_iss),
    .addr     (age_addr),
    .data     (age_data),
    .found    (pick_found),
    .pos      (pick_pos),
    .fwd      (pick_fwd),
    .fwd_data (pick_fdata),
    .ld_addr  (pick_addr)
  );

  assign do_issue   = pick_found & ~flush_valid;
  assign issue_slot = head_q + pick_pos;

  // slot next-state
  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      logic alloc, aupd, dupd, iss;
      alloc = do_push & (tail_q == PW'(s));
      aupd  = addr_upd_valid & slot_v[s] & (seq_q[s] == addr_upd_seq);
      dupd  = data_upd_valid & slot_v[s] & flg_q[s].is_st & (seq_q[s] == data_upd_seq);
      iss   = do_issue & (issue_slot == PW'(s));
      seq_d[s]  = seq_q[s];
      addr_d[s] = addr_q[s];
      data_d[s] = data_q[s];
      flg_d[s]  = flg_q[s];
      if (alloc) begin
        seq_d[s] = disp_seq;
        flg_d[s] = '{is_st: disp_is_store, addr_v: 1'b0, data_v: 1'b0, issued: 1'b0};
      end else begin
        if (aupd) begin
          addr_d[s]        = addr_upd_addr;
          flg_d[s].addr_v  = 1'b1;
        end
        if (dupd) begin
          data_d[s]        = data_upd_data;
          flg_d[s].data_v  = 1'b1;
        end
        if (iss) flg_d[s].issued = 1'b1;
      end
      slot_en[s] = alloc | aupd | dupd | iss;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (slot_en[s]) begin
        seq_q[s]  <= seq_d[s];
        addr_q[s] <= addr_d[s];
        data_q[s] <= data_d[s];
        flg_q[s]  <= flg_d[s];
      end
    end
  end

  // response stage
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) resp_v_q <= 1'b0;
    else             resp_v_q <= do_issue;
  end

  always_ff @(posedge clk) begin
    if (do_issue) begin
      resp_seq_q   <= age_seq[pick_pos];
      resp_src_q   <= pick_fwd ? SRC_FWD : SRC_CACHE;
      resp_fdata_q <= pick_fdata;
    end
  end

  assign cache_rd_en   = do_issue & ~pick_fwd;
  assign cache_rd_addr = pick_addr;

  assign cache_wr_en   = do_pop & flg_q[head_q].is_st;
  assign cache_wr_addr = addr_q[head_q];
  assign cache_wr_data = data_q[head_q];

  assign ld_resp_valid = resp_v_q;
  assign ld_resp_seq   = resp_seq_q;
  assign ld_resp_fwd   = (resp_src_q == SRC_FWD);
  assign ld_resp_data  = (resp_src_q == SRC_FWD) ? resp_fdata_q : cache_rd_data;
endmodule

// File: rtl/memq_chk.sv
module memq_chk #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic [PW:0] count,
  input logic        disp_ready,
  input logic        commit_valid,
  input logic        flush_valid,
  input logic        issue_any,
  input logic        cache_rd_en,
  input logic        cache_wr_en,
  input logic        ld_resp_valid,
  input logic        ld_resp_fwd
);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R2
  ready_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) < DEPTH && !flush_valid) |-> disp_ready);

  // R9
  wr_only_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr_en |-> (commit_valid && !flush_valid));

  // R6
  cache_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_rd_en |=> (ld_resp_valid && !ld_resp_fwd));

  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (!cache_rd_en && !cache_wr_en && !disp_ready));

  // R7
  resp_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_resp_valid) |-> $past(issue_any));
endmodule

bind memq_lsq memq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .count         (count_q),
  .disp_ready    (disp_ready),
  .commit_valid  (commit_valid),
  .flush_valid   (flush_valid),
  .issue_any     (do_issue),
  .cache_rd_en   (cache_rd_en),
  .cache_wr_en   (cache_wr_en),
  .ld_resp_valid (ld_resp_valid),
  .ld_resp_fwd   (ld_resp_fwd)
);

// File: tb/sim_memq_lsq.sv
module sim_memq_lsq;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int SW = 8;

  logic clk, rst_n;
  logic disp_valid, disp_is_store, disp_ready;
  logic [SW-1:0] disp_seq, addr_upd_seq, data_upd_seq, flush_seq, ld_resp_seq;
  logic addr_upd_valid, data_upd_valid, commit_valid, flush_valid;
  logic [AW-1:0] addr_upd_addr, cache_rd_addr, cache_wr_addr;
  logic [DW-1:0] data_upd_data, cache_rd_data, cache_wr_data, ld_resp_data;
  logic cache_rd_en, cache_wr_en, ld_resp_valid, ld_resp_fwd;

  int checks = 0;
  int errors = 0;

  memq_lsq #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SW(SW)) u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // cache model: one-cycle read, write at edge
  logic [DW-1:0] mem [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'h1000 + 16'(i);
    end else begin
      if (cache_rd_en) cache_rd_data <= mem[cache_rd_addr[7:0]];
      if (cache_wr_en) mem[cache_wr_addr[7:0]] <= cache_wr_data;
    end
  end

  // response monitor, sampled away from the edge
  int resp_cnt = 0;
  int wr_cnt = 0;
  logic [SW-1:0] last_seq;
  logic [DW-1:0] last_data;
  logic last_fwd;
  logic [SW-1:0] seq_log [64];
  always @(negedge clk) begin
    if (ld_resp_valid) begin
      last_seq  = ld_resp_seq;
      last_data = ld_resp_data;
      last_fwd  = ld_resp_fwd;
      seq_log[resp_cnt % 64] = ld_resp_seq;
      resp_cnt++;
    end
    if (cache_wr_en) wr_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dispatch(input logic st, input logic [SW-1:0] sq);
    @(negedge clk);
    disp_valid = 1'b1; disp_is_store = st; disp_seq = sq;
    @(posedge clk); #1;
    disp_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [SW-1:0] sq, input logic [AW-1:0] a);
    @(negedge clk);
    addr_upd_valid = 1'b1; addr_upd_seq = sq; addr_upd_addr = a;
    @(posedge clk); #1;
    addr_upd_valid = 1'b0;
  endtask

  task automatic set_data(input logic [SW-1:0] sq, input logic [DW-1:0] d);
    @(negedge clk);
    data_upd_valid = 1'b1; data_upd_seq = sq; data_upd_data = d;
    @(posedge clk); #1;
    data_upd_valid = 1'b0;
  endtask

  task automatic flush(input logic [SW-1:0] sq);
    @(negedge clk);
    flush_valid = 1'b1; flush_seq = sq;
    #1 chk("R10 disp_ready in flush", int'(disp_ready), 0);
    @(posedge clk); #1;
    flush_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // forwarding vectors: two older writes, one read
  typedef struct packed {
    logic [15:0] a1, d1, a2, d2, la, exp;
    logic        fwd;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{16'h0010, 16'h00AA, 16'h0020, 16'h00BB, 16'h0030, 16'h1030, 1'b0},
    '{16'h0030, 16'hAAAA, 16'h0020, 16'hBBBB, 16'h0030, 16'hAAAA, 1'b1},
    '{16'h0030, 16'hFFEF, 16'h0030, 16'h0000, 16'h0030, 16'h0000, 1'b1},
    '{16'h0040, 16'h1111, 16'h0040, 16'h2222, 16'h0041, 16'h1041, 1'b0},
    '{16'h0055, 16'h5555, 16'h0066, 16'h6666, 16'h0066, 16'h6666, 1'b1}
  };

  initial begin
    int n0, w0;
    rst_n = 1'b0;
    disp_valid = 0; disp_is_store = 0; disp_seq = 0;
    addr_upd_valid = 0; addr_upd_seq = 0; addr_upd_addr = 0;
    data_upd_valid = 0; data_upd_seq = 0; data_upd_data = 0;
    commit_valid = 0; flush_valid = 0; flush_seq = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 disp_ready", int'(disp_ready), 1);
    chk("R1 cache_rd_en", int'(cache_rd_en), 0);
    chk("R1 cache_wr_en", int'(cache_wr_en), 0);
    chk("R1 ld_resp_valid", int'(ld_resp_valid), 0);

    // R4 R6 vector walk
    for (int r = 0; r < 5; r++) begin
      logic [SW-1:0] b;
      b = SW'(20 + 10 * r);
      n0 = resp_cnt;
      dispatch(1'b1, b);
      dispatch(1'b1, b + 1);
      dispatch(1'b0, b + 2);
      set_addr(b, VEC[r].a1);
      set_addr(b + 1, VEC[r].a2);
      set_addr(b + 2, VEC[r].la);
      set_data(b, VEC[r].d1);
      set_data(b + 1, VEC[r].d2);
      idle(4);
      chk("R7 one response per read", resp_cnt - n0, 1);
      chk("R4/R6 read data", int'(last_data), int'(VEC[r].exp));
      chk("R4/R6 forward flag", int'(last_fwd), int'(VEC[r].fwd));
      chk("R7 response seq", int'(last_seq), int'(b + 2));
      flush(b - 1);
    end

    // R3 unknown older write address blocks the read
    n0 = resp_cnt;
    dispatch(1'b1, 8'd100);
    dispatch(1'b0, 8'd101);
    set_addr(8'd101, 16'h0030);
    idle(4);
    chk("R3 read held", resp_cnt - n0, 0);
    set_addr(8'd100, 16'h0031);
    idle(3);
    chk("R3 read released", resp_cnt - n0, 1);
    chk("R6 cache data", int'(last_data), 16'h1030);
    set_data(8'd100, 16'h4242);
    // R9 no write before commit
    chk("R9 memory before commit", int'(mem[8'h31]), 16'h1031);
    chk("R9 no early write", wr_cnt, 0);
    // R8 commit of a write
    @(negedge clk);
    commit_valid = 1'b1;
    #1;
    chk("R8 wr_en", int'(cache_wr_en), 1);
    chk("R8 wr_addr", int'(cache_wr_addr), 16'h0031);
    chk("R8 wr_data", int'(cache_wr_data), 16'h4242);
    @(negedge clk);
    #1;
    chk("R8 read commit no write", int'(cache_wr_en), 0);
    @(posedge clk); #1;
    commit_valid = 1'b0;
    idle(1);
    chk("R8 memory after commit", int'(mem[8'h31]), 16'h4242);

    // R5 matching write without data
    n0 = resp_cnt;
    dispatch(1'b1, 8'd110);
    dispatch(1'b0, 8'd111);
    set_addr(8'd110, 16'h0050);
    set_addr(8'd111, 16'h0050);
    idle(4);
    chk("R5 read waits", resp_cnt - n0, 0);
    set_data(8'd110, 16'h9999);
    idle(3);
    chk("R5 read after data", resp_cnt - n0, 1);
    chk("R5 forwarded value", int'(last_data), 16'h9999);
    flush(8'd109);

    // R4 younger write ignored
    n0 = resp_cnt;
    dispatch(1'b0, 8'd120);
    dispatch(1'b1, 8'd121);
    set_addr(8'd121, 16'h0060);
    set_data(8'd121, 16'h7777);
    set_addr(8'd120, 16'h0060);
    idle(3);
    chk("R4 younger ignored data", int'(last_data), 16'h1060);
    chk("R4 younger ignored fwd", int'(last_fwd), 0);
    flush(8'd119);

    // R7 oldest ready read first, each once
    n0 = resp_cnt;
    dispatch(1'b1, 8'd130);
    dispatch(1'b0, 8'd131);
    dispatch(1'b0, 8'd132);
    set_addr(8'd131, 16'h0071);
    set_addr(8'd132, 16'h0072);
    set_addr(8'd130, 16'h0099);
    idle(5);
    chk("R7 two responses", resp_cnt - n0, 2);
    chk("R7 first is oldest", int'(seq_log[n0 % 64]), 131);
    chk("R7 second", int'(seq_log[(n0 + 1) % 64]), 132);
    flush(8'd129);

    // R2 full queue
    for (int i = 0; i < DEPTH; i++) dispatch(1'b0, SW'(140 + i));
    idle(1);
    chk("R2 full blocks dispatch", int'(disp_ready), 0);
    flush(8'd139);
    idle(1);
    chk("R2 room after flush", int'(disp_ready), 1);

    // R10 partial flush then commits
    w0 = wr_cnt;
    dispatch(1'b1, 8'd150);
    dispatch(1'b1, 8'd151);
    set_addr(8'd150, 16'h0080);
    set_data(8'd150, 16'hABCD);
    set_addr(8'd151, 16'h0081);
    set_data(8'd151, 16'h1212);
    flush(8'd150);
    @(negedge clk);
    commit_valid = 1'b1;
    #1 chk("R10 kept write commits", int'(cache_wr_addr), 16'h0080);
    @(negedge clk);
    #1 chk("R8 empty commit no write", int'(cache_wr_en), 0);
    @(posedge clk); #1;
    commit_valid = 1'b0;
    idle(1);
    chk("R10 flushed write absent", int'(mem[8'h81]), 16'h1081);
    chk("R10 one write total", wr_cnt - w0, 1);

    // R10 flush across sequence wrap
    n0 = resp_cnt;
    dispatch(1'b0, 8'd255);
    dispatch(1'b0, 8'd0);
    flush(8'd255);
    set_addr(8'd0, 16'h0090);
    idle(3);
    chk("R10 wrapped younger removed", resp_cnt - n0, 0);
    set_addr(8'd255, 16'h0091);
    idle(3);
    chk("R10 older kept", resp_cnt - n0, 1);
    chk("R10 kept seq", int'(last_seq), 255);
    chk("R6 kept data", int'(last_data), 16'h1091);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule